// File: doc/BRIEF.md
# Dual-Output Read Serializer

This block is the output data path of a serial memory read. During the read it sends the bytes supplied by the memory side out on two bidirectional pins. In single mode it sends one bit per falling serial-clock edge on the IO1 pin. In dual mode the IO0 pin, which carries host input during the rest of the transfer, is turned around so that two bits leave on every falling edge. The block works in a system clock domain. The serial clock reaches it as one-cycle strobes for its rising and falling edges, already synchronised by the interface logic around it.

After the device is selected, the block counts a parameterised number of rising serial-clock edges. These edges cover the opcode, address and dummy clocks. On the last of them it samples the width flag chosen by the opcode decoder, and from then on it drives data. The memory side keeps the next byte stable on `byte_i`. The block takes that byte on the falling edge that starts a byte. It raises `byte_req_o` together with the last bits of the current byte, so the memory side can present the following byte before the next edge. Deselecting the device clears everything. Holding the device freezes everything and releases both pins.

Top module: `dual_read_serializer`

## Requirements
- R1: While `sel_i` is low, `io1_oe_o` and `io0_oe_o` are both low, and the next selection starts the header count from zero.
- R2: While `hold_i` is high, both output enables are low and edge strobes have no effect: after hold is released, the next falling edge sends the slot that was due before the hold.
- R3: Neither output enable is high until `HDR_CLKS` qualified rising strobes have been counted since selection. `io1_oe_o` is high in the cycle after the strobe that completes the count.
- R4: In single mode (`dual_i` = 0 at the last header strobe), each qualified falling strobe puts the next bit of the byte on `io1_out_o`, MSB first. `io0_oe_o` stays low and `io0_out_o` stays 0.
- R5: In dual mode (`dual_i` = 1 at the last header strobe), both output enables are high during the data phase. Each falling strobe sends one bit pair: the higher bit goes on `io1_out_o` and the lower bit on `io0_out_o`, in the order [7:6], [5:4], [3:2], [1:0].
- R6: `byte_req_o` is high for exactly one cycle. That cycle is the one in which the pins show the last slot of a byte (bit 0 in single mode, pair [1:0] in dual mode). It is low in every other cycle.
- R7: The falling strobe after the last slot of a byte sends the first slot of the value then on `byte_i`, with no idle edge between the two bytes.
- R8: The width mode is fixed for the whole data phase. A change of `dual_i` after the last header strobe has no effect on the pins until the device is deselected.
- R9: While `rst` is high, both output enables, both data outputs and `byte_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Device selected (active high) |
| hold_i | input | 1 | Transfer paused (active high) |
| sck_rise_i | input | 1 | One-cycle strobe for a rising serial-clock edge |
| sck_fall_i | input | 1 | One-cycle strobe for a falling serial-clock edge |
| dual_i | input | 1 | Width flag from the opcode decoder: 1 = two bits per edge |
| byte_i | input | DATA_W | Next byte from the memory side |
| byte_req_o | output | 1 | Current byte fully sent; present the next one |
| io1_out_o | output | 1 | Data value for the IO1 pin |
| io1_oe_o | output | 1 | Output enable for the IO1 pin |
| io0_out_o | output | 1 | Data value for the IO0 pin |
| io0_oe_o | output | 1 | Output enable for the IO0 pin |

## Verification
The bench builds the block with `DATA_W` = 8 and `HDR_CLKS` = 6. With a header this short, every transfer in the test reaches the data phase after a few strobes. This leaves room for many transfers that each span two back-to-back bytes, in both widths. It also makes the exact edge at which the pins turn on easy to place. At eight bits, all four pair positions and all eight serial positions are visible, along with the byte-boundary request. The same short header lets the bench reselect in the middle of a byte and check that the count restarts from zero.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    typedef enum logic {
        LANE_SINGLE = 1'b0,
        LANE_DUAL   = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } pin_pair_t;

    function automatic int unsigned slots_per_word(input lane_mode_e m, input int unsigned w);
        return (m == LANE_DUAL) ? (w / 2) : w;
    endfunction

endpackage

// File: rtl/dsr_phase_track.sv
module dsr_phase_track
    import dsr_pkg::*;
#(
    parameter int unsigned HDR_CLKS = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_i,
    input  logic       hold_i,
    input  logic       sck_rise_i,
    input  logic       dual_i,
    output logic       data_phase_o,
    output lane_mode_e mode_o
);
    localparam int unsigned CNT_W = $clog2(HDR_CLKS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;
    lane_mode_e       mode_q;
    logic             rise_ok;

    assign rise_ok = sck_rise_i && !hold_i && !phase_q;

    always_ff @(posedge clk) begin
        if (rst || !sel_i) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
            mode_q  <= LANE_SINGLE;
        end else if (rise_ok) begin
            if (cnt_q == CNT_W'(HDR_CLKS - 1)) begin
                cnt_q   <= '0;
                phase_q <= 1'b1;
                mode_q  <= dual_i ? LANE_DUAL : LANE_SINGLE;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign data_phase_o = phase_q;
    assign mode_o       = mode_q;

    // R8: width mode frozen for the whole data phase
    p_mode_frozen_r8: assert property (@(posedge clk) disable iff (rst || !sel_i)
        (phase_q && $past(phase_q)) |-> $stable(mode_q));

    // R3: the counter never runs past the header length
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(HDR_CLKS));

endmodule

// File: rtl/dsr_shifter.sv
module dsr_shifter
    import dsr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              step_i,
    input  lane_mode_e        mode_i,
    input  logic [DATA_W-1:0] byte_i,
    output pin_pair_t         pins_o,
    output logic              req_o
);
    localparam int unsigned SLOT_W = $clog2(DATA_W);
    localparam int unsigned DUAL_SLOTS   = DATA_W / 2;
    localparam int unsigned SINGLE_SLOTS = DATA_W;

    logic [SLOT_W-1:0] slot_q;
    logic [DATA_W-1:0] shreg_q;
    pin_pair_t         pins_q;
    logic              req_q;

    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] word_next;
    pin_pair_t         pins_next;
    logic              slot_is_last;

    assign word = (slot_q == '0) ? byte_i : shreg_q;

    always_comb begin
        if (mode_i == LANE_DUAL) begin
            pins_next.hi = word[DATA_W-1];
            pins_next.lo = word[DATA_W-2];
            word_next    = {word[DATA_W-3:0], 2'b00};
            slot_is_last = (slot_q == SLOT_W'(DUAL_SLOTS - 1));
        end else begin
            pins_next.hi = word[DATA_W-1];
            pins_next.lo = 1'b0;
            word_next    = {word[DATA_W-2:0], 1'b0};
            slot_is_last = (slot_q == SLOT_W'(SINGLE_SLOTS - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            slot_q  <= '0;
            shreg_q <= '0;
            pins_q  <= '0;
            req_q   <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (step_i) begin
                pins_q  <= pins_next;
                shreg_q <= word_next;
                slot_q  <= slot_is_last ? '0 : slot_q + 1'b1;
                req_q   <= slot_is_last;
            end
        end
    end

    assign pins_o = pins_q;
    assign req_o  = req_q;

    // R6: a request is a single-cycle pulse
    p_req_single_r6: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q);

    // R6: a request coincides with the slot counter wrapping to the byte start
    p_req_at_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        req_q |-> (slot_q == '0));

    // R5: in dual mode the slot index stays below the pair count
    p_dual_slot_range_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_i == LANE_DUAL) |-> (slot_q < SLOT_W'(DUAL_SLOTS)));

endmodule

// File: rtl/dsr_pin_gate.sv
module dsr_pin_gate
    import dsr_pkg::*;
(
    input  logic       sel_i,
    input  logic       hold_i,
    input  logic       data_phase_i,
    input  lane_mode_e mode_i,
    input  pin_pair_t  pins_i,
    output logic       io1_out_o,
    output logic       io1_oe_o,
    output logic       io0_out_o,
    output logic       io0_oe_o
);
    logic drive_ok;

    always_comb begin
        drive_ok  = sel_i && !hold_i && data_phase_i;
        io1_oe_o  = drive_ok;
        io0_oe_o  = drive_ok && (mode_i == LANE_DUAL);
        io1_out_o = pins_i.hi;
        io0_out_o = (mode_i == LANE_DUAL) ? pins_i.lo : 1'b0;
    end

endmodule

// File: rtl/dual_read_serializer.sv
module dual_read_serializer
    import dsr_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned HDR_CLKS = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              hold_i,
    input  logic              sck_rise_i,
    input  logic              sck_fall_i,
    input  logic              dual_i,
    input  logic [DATA_W-1:0] byte_i,
    output logic              byte_req_o,
    output logic              io1_out_o,
    output logic              io1_oe_o,
    output logic              io0_out_o,
    output logic              io0_oe_o
);
    logic       data_phase;
    lane_mode_e mode;
    pin_pair_t  pins;
    logic       step;
    logic       clear;

    assign step  = sck_fall_i && sel_i && !hold_i && data_phase;
    assign clear = !sel_i || !data_phase;

    dsr_phase_track #(
        .HDR_CLKS (HDR_CLKS)
    ) u_phase (
        .clk          (clk),
        .rst          (rst),
        .sel_i        (sel_i),
        .hold_i       (hold_i),
        .sck_rise_i   (sck_rise_i),
        .dual_i       (dual_i),
        .data_phase_o (data_phase),
        .mode_o       (mode)
    );

    dsr_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear),
        .step_i  (step),
        .mode_i  (mode),
        .byte_i  (byte_i),
        .pins_o  (pins),
        .req_o   (byte_req_o)
    );

    dsr_pin_gate u_gate (
        .sel_i        (sel_i),
        .hold_i       (hold_i),
        .data_phase_i (data_phase),
        .mode_i       (mode),
        .pins_i       (pins),
        .io1_out_o    (io1_out_o),
        .io1_oe_o     (io1_oe_o),
        .io0_out_o    (io0_out_o),
        .io0_oe_o     (io0_oe_o)
    );

    // R1: both pins released while deselected
    p_hiz_desel_r1: assert property (@(posedge clk) disable iff (rst)
        !sel_i |-> (!io1_oe_o && !io0_oe_o));

    // R2: both pins released during hold
    p_hiz_hold_r2: assert property (@(posedge clk) disable iff (rst)
        hold_i |-> (!io1_oe_o && !io0_oe_o));

    // R2: pin values and request frozen across a held cycle
    p_hold_freeze_r2: assert property (@(posedge clk) disable iff (rst || !sel_i)
        (hold_i && !byte_req_o) |=> ($stable(io1_out_o) && $stable(io0_out_o) && !byte_req_o));

    // R3: nothing driven before the header is complete
    p_no_drive_hdr_r3: assert property (@(posedge clk) disable iff (rst)
        !data_phase |-> (!io1_oe_o && !io0_oe_o && !byte_req_o));

    // R4: IO0 never driven in single mode
    p_io0_input_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == LANE_SINGLE) |-> (!io0_oe_o && !io0_out_o));

    // R9: quiet outputs under reset
    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (!byte_req_o && !io1_out_o && !io0_out_o));

endmodule

// File: tb/dual_read_serializer_tb.sv
`timescale 1ns/1ps
module dual_read_serializer_tb;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned HDR_CLKS = 6;
    localparam int unsigned NVEC     = 6;

    // {dual, first byte, second byte}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b0, 8'hA5, 8'h3C},
        {1'b1, 8'hA5, 8'h3C},
        {1'b1, 8'hFF, 8'h00},
        {1'b0, 8'h81, 8'h7E},
        {1'b1, 8'h1B, 8'hE4},
        {1'b0, 8'h00, 8'hFF}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sel_i = 1'b0;
    logic              hold_i = 1'b0;
    logic              sck_rise_i = 1'b0;
    logic              sck_fall_i = 1'b0;
    logic              dual_i = 1'b0;
    logic [DATA_W-1:0] byte_i = '0;
    logic              byte_req_o, io1_out_o, io1_oe_o, io0_out_o, io0_oe_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dual_read_serializer #(
        .DATA_W   (DATA_W),
        .HDR_CLKS (HDR_CLKS)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .sel_i      (sel_i),
        .hold_i     (hold_i),
        .sck_rise_i (sck_rise_i),
        .sck_fall_i (sck_fall_i),
        .dual_i     (dual_i),
        .byte_i     (byte_i),
        .byte_req_o (byte_req_o),
        .io1_out_o  (io1_out_o),
        .io1_oe_o   (io1_oe_o),
        .io0_out_o  (io0_out_o),
        .io0_oe_o   (io0_oe_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rise_edge();
        @(negedge clk); sck_rise_i = 1'b1;
        @(negedge clk); sck_rise_i = 1'b0;
    endtask

    task automatic fall_edge();
        @(negedge clk); sck_fall_i = 1'b1;
        @(negedge clk); sck_fall_i = 1'b0;
    endtask

    // select, send the header, check enables before and after its last strobe
    task automatic open_read(input logic dual, input string req);
        @(negedge clk); sel_i = 1'b0;
        @(negedge clk); sel_i = 1'b1; dual_i = dual;
        for (int i = 0; i < int'(HDR_CLKS) - 1; i++) rise_edge();
        chk(req, {6'd0, io1_oe_o, io0_oe_o}, 8'd0);
        rise_edge();
        chk(req, {6'd0, io1_oe_o, io0_oe_o}, {6'd0, 1'b1, dual});
    endtask

    // send one byte and compare every slot; next byte presented after the request
    task automatic send_byte(input logic dual, input logic [7:0] b, input logic [7:0] nxt, input string req);
        int step  = dual ? 2 : 1;
        int slots = 8 / step;
        for (int s = 0; s < slots; s++) begin
            logic eh, el, er;
            fall_edge();
            eh = b[7 - s*step];
            el = dual ? b[6 - s*step] : 1'b0;
            er = (s == slots - 1);
            chk(req, {4'd0, io1_out_o, io0_out_o, io0_oe_o, byte_req_o},
                     {4'd0, eh, el, dual, er});
            if (byte_req_o) byte_i = nxt;
        end
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state with the device selected
        sel_i = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", {3'd0, io1_oe_o, io0_oe_o, io1_out_o, io0_out_o, byte_req_o}, 8'd0);
        @(negedge clk); rst = 1'b0; sel_i = 1'b0;

        // R3 R4 R5 R6 R7: table of transfers, two back-to-back bytes each
        for (int v = 0; v < int'(NVEC); v++) begin
            logic       d;
            logic [7:0] b0, b1;
            {d, b0, b1} = VEC[v];
            byte_i = b0;
            open_read(d, "R3");
            send_byte(d, b0, b1, d ? "R5" : "R4");
            send_byte(d, b1, 8'h00, "R7");
            @(negedge clk);
            chk("R6", {7'd0, byte_req_o}, 8'd0);
        end

        // R1: deselect releases both pins
        @(negedge clk); sel_i = 1'b0;
        @(negedge clk);
        chk("R1", {6'd0, io1_oe_o, io0_oe_o}, 8'd0);

        // R2: hold in the middle of a dual byte (C6: 11 00 01 10)
        byte_i = 8'hC6;
        open_read(1'b1, "R3");
        fall_edge();
        chk("R2", {6'd0, io1_out_o, io0_out_o}, 8'b11);
        fall_edge();
        chk("R2", {6'd0, io1_out_o, io0_out_o}, 8'b00);
        @(negedge clk); hold_i = 1'b1;
        @(negedge clk);
        chk("R2", {6'd0, io1_oe_o, io0_oe_o}, 8'd0);
        fall_edge();
        fall_edge();
        rise_edge();
        chk("R2", {6'd0, io1_oe_o, io0_oe_o}, 8'd0);
        @(negedge clk); hold_i = 1'b0;
        fall_edge();
        chk("R2", {5'd0, io1_oe_o, io1_out_o, io0_out_o}, 8'b101);
        fall_edge();
        chk("R2", {5'd0, io1_out_o, io0_out_o, byte_req_o}, 8'b101);

        // R8: width flag flipped in the data phase is ignored (5A: 01 01 10 10)
        byte_i = 8'h5A;
        open_read(1'b1, "R3");
        fall_edge();
        @(negedge clk); dual_i = 1'b0;
        fall_edge();
        chk("R8", {5'd0, io0_oe_o, io1_out_o, io0_out_o}, 8'b101);
        fall_edge();
        chk("R8", {5'd0, io0_oe_o, io1_out_o, io0_out_o}, 8'b110);

        // R1: reselect mid-byte restarts header count and byte
        @(negedge clk); sel_i = 1'b0;
        @(negedge clk);
        chk("R1", {6'd0, io1_oe_o, io0_oe_o}, 8'd0);
        byte_i = 8'h80;
        open_read(1'b0, "R1");
        fall_edge();
        chk("R1", {6'd0, io1_out_o, byte_req_o}, 8'b10);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule